// File: doc/BRIEF.md
# Bus Wait-State Generator

This block drives the ready line of a 16-bit processor bus, stretching each bus cycle by zero to seven wait states. It watches the address-latch strobe. When that strobe ends it captures a wait count for the new cycle. The count is chosen from the address-space status (memory or I/O), the region flags supplied by an external address decoder, and the cycle direction. Ready is registered and is meant to feed a clock-generator style synchronizer. At a 5 MHz bus clock, each wait state adds one 200 ns clock period.

Fixed region timings are parameters. By default a ROM read waits two clocks, any RAM access waits one, and any I/O cycle waits none. A memory cycle that falls outside both decoded regions uses a 3-bit default count that is written through a small load port. The read and write strobes are expected to be valid when the address-latch strobe falls.

Top module: `bus_wait_gen`

## Requirements
- R1: While reset is low, and right after reset is asserted in the middle of a cycle, `rdy` is 1 and no wait state is pending.
- R2: A new cycle starts on the clock edge that sees `ale` low after it was high. `rdy` stays 1 while `ale` is high, and it falls on that edge when the selected count is non-zero.
- R3: A memory read (`rd_n`=0, `wr_n`=1) with `rom_sel`=1 holds `rdy` low for exactly 2 clocks.
- R4: A memory read or write with `ram_sel`=1 and `rom_sel`=0 holds `rdy` low for exactly 1 clock.
- R5: A cycle with `is_mem`=0 (I/O space) inserts no wait state, whatever the region flags show.
- R6: A memory cycle with both region flags at 0 uses the default count. The default count resets to 3.
- R7: A selected count of 0 keeps `rdy` at 1 for the whole cycle.
- R8: Once the wait count reaches zero, `rdy` returns to 1 and stays at 1 until the next cycle start. The count never wraps below zero.
- R9: `rom_sel` takes priority over `ram_sel`. A write (`wr_n`=0) with `rom_sel`=1 inserts no wait state.
- R10: A clock edge with `dflt_we`=1 stores `dflt_din` as the default count. Every count from 0 to 7 is honoured, so a default of 7 gives 7 wait states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address-latch strobe, active high |
| is_mem | input | 1 | 1 = memory space, 0 = I/O space |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rom_sel | input | 1 | Decoder flag: ROM region hit |
| ram_sel | input | 1 | Decoder flag: RAM region hit |
| dflt_we | input | 1 | Load enable for the default count |
| dflt_din | input | 3 | New default count |
| rdy | output | 1 | Registered ready, low while waiting |

## Verification
The assertions check on every cycle that the count loaded for ROM reads, RAM accesses and I/O cycles matches its parameter. They also check that the count steps down by exactly one per clock and holds at zero, that ready is low whenever a wait is pending, and that a cycle start lasts only one clock. Only the bench scenarios can show the end-to-end effect seen at the pins. These are the number of low ready clocks per cycle type, the default register's reset value and its reprogramming to 0 and 7, the ROM-over-RAM priority, and the recovery from a reset applied mid-cycle.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

   localparam int unsigned BWG_CNT_W = 3;

   typedef enum logic [1:0] {
      SPACE_IO    = 2'd0,
      SPACE_ROM   = 2'd1,
      SPACE_RAM   = 2'd2,
      SPACE_OTHER = 2'd3
   } bwg_space_e;

endpackage

// File: rtl/bwg_strobe.sv
module bwg_strobe #(
   parameter bit ALE_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ale,
   output logic cyc_start
);

   logic ale_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ale_q <= ~ALE_ACTIVE_HIGH;
      else        ale_q <= ale;
   end

   generate
      if (ALE_ACTIVE_HIGH) begin : g_high
         assign cyc_start = ale_q & ~ale;
      end else begin : g_low
         assign cyc_start = ~ale_q & ale;
      end
   endgenerate

   // R2: a cycle start is a single-clock event
   p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |=> !cyc_start);

endmodule

// File: rtl/bwg_count_sel.sv
module bwg_count_sel
   import bwg_pkg::*;
#(
   parameter int unsigned CNT_W     = BWG_CNT_W,
   parameter int unsigned ROM_WAITS = 2,
   parameter int unsigned RAM_WAITS = 1,
   parameter int unsigned IO_WAITS  = 0,
   parameter int unsigned DFLT_RST  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             is_mem,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic             rom_sel,
   input  logic             ram_sel,
   input  logic             dflt_we,
   input  logic [CNT_W-1:0] dflt_din,
   output bwg_space_e       space,
   output logic [CNT_W-1:0] sel_cnt
);

   localparam logic [CNT_W-1:0] ROM_C  = CNT_W'(ROM_WAITS);
   localparam logic [CNT_W-1:0] RAM_C  = CNT_W'(RAM_WAITS);
   localparam logic [CNT_W-1:0] IO_C   = CNT_W'(IO_WAITS);
   localparam logic [CNT_W-1:0] DFLT_C = CNT_W'(DFLT_RST);

   logic [CNT_W-1:0] dflt_q;
   logic             is_write;

   assign is_write = ~wr_n & rd_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dflt_q <= DFLT_C;
      else if (dflt_we) dflt_q <= dflt_din;
   end

   always_comb begin
      if (!is_mem)      space = SPACE_IO;
      else if (rom_sel) space = SPACE_ROM;
      else if (ram_sel) space = SPACE_RAM;
      else              space = SPACE_OTHER;
   end

   always_comb begin
      unique case (space)
         SPACE_IO:    sel_cnt = IO_C;
         SPACE_ROM:   sel_cnt = is_write ? '0 : ROM_C;
         SPACE_RAM:   sel_cnt = RAM_C;
         default:     sel_cnt = dflt_q;
      endcase
   end

   // R6: a write to the default register lands on the next edge
   p_dflt_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dflt_we |=> dflt_q == $past(dflt_din));

endmodule

// File: rtl/bwg_counter.sv
module bwg_counter #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] remain,
   output logic             rdy
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rdy   <= 1'b1;
      end else if (load) begin
         cnt_q <= load_val;
         rdy   <= (load_val == '0);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - ONE;
         rdy   <= (cnt_q == ONE);
      end
   end

   assign remain = cnt_q;

   // R8: count steps down by one per clock
   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);

   // R8: no wrap below zero, ready stays high while idle
   p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q == '0) |=> (cnt_q == '0) && rdy);

   // R7: ready is low while any wait is pending
   p_rdy_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> !rdy);

   // R7: zero load keeps ready high
   p_zero_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val == '0) |=> rdy);

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
   import bwg_pkg::*;
#(
   parameter int unsigned CNT_W           = BWG_CNT_W,
   parameter int unsigned ROM_WAITS       = 2,
   parameter int unsigned RAM_WAITS       = 1,
   parameter int unsigned IO_WAITS        = 0,
   parameter int unsigned DFLT_RST        = 3,
   parameter bit          ALE_ACTIVE_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ale,
   input  logic             is_mem,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic             rom_sel,
   input  logic             ram_sel,
   input  logic             dflt_we,
   input  logic [CNT_W-1:0] dflt_din,
   output logic             rdy
);

   localparam int unsigned MAX_WAITS = (1 << CNT_W) - 1;

   initial begin
      p_cfg_width_r10: assert (CNT_W >= 1 && CNT_W <= 8)
         else $error("CNT_W out of range");
      p_cfg_counts_r10: assert (ROM_WAITS <= MAX_WAITS && RAM_WAITS <= MAX_WAITS &&
                                IO_WAITS <= MAX_WAITS && DFLT_RST <= MAX_WAITS)
         else $error("wait count exceeds counter range");
   end

   logic             cyc_start;
   bwg_space_e       space;
   logic [CNT_W-1:0] sel_cnt;
   logic [CNT_W-1:0] remain;

   bwg_strobe #(.ALE_ACTIVE_HIGH(ALE_ACTIVE_HIGH)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .ale       (ale),
      .cyc_start (cyc_start)
   );

   bwg_count_sel #(
      .CNT_W     (CNT_W),
      .ROM_WAITS (ROM_WAITS),
      .RAM_WAITS (RAM_WAITS),
      .IO_WAITS  (IO_WAITS),
      .DFLT_RST  (DFLT_RST)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .is_mem   (is_mem),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .rom_sel  (rom_sel),
      .ram_sel  (ram_sel),
      .dflt_we  (dflt_we),
      .dflt_din (dflt_din),
      .space    (space),
      .sel_cnt  (sel_cnt)
   );

   bwg_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cyc_start),
      .load_val (sel_cnt),
      .remain   (remain),
      .rdy      (rdy)
   );

   // R3: ROM read loads the ROM wait count
   p_rom_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && is_mem && rom_sel && wr_n && !rd_n) |=> remain == CNT_W'(ROM_WAITS));

   // R4: RAM access loads the RAM wait count
   p_ram_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && is_mem && ram_sel && !rom_sel) |=> remain == CNT_W'(RAM_WAITS));

   // R5: I/O space loads the I/O wait count
   p_io_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !is_mem) |=> remain == CNT_W'(IO_WAITS));

   // R9: ROM write inserts nothing
   p_rom_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && is_mem && rom_sel && !wr_n && rd_n) |=> rdy);

   // R2: ready only falls at a cycle start
   p_fall_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !cyc_start) |=> rdy);

   // R1: the region encoding stays legal
   p_space_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(space));

endmodule

// File: tb/bus_wait_gen_bench.sv
module bus_wait_gen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ale = 1'b0;
   logic       is_mem = 1'b0;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic       rom_sel = 1'b0;
   logic       ram_sel = 1'b0;
   logic       dflt_we = 1'b0;
   logic [2:0] dflt_din = 3'd0;
   logic       rdy;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   bus_wait_gen u_bus_wait_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .ale      (ale),
      .is_mem   (is_mem),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .rom_sel  (rom_sel),
      .ram_sel  (ram_sel),
      .dflt_we  (dflt_we),
      .dflt_din (dflt_din),
      .rdy      (rdy)
   );

   // vector: [7] is_mem, [6] rom_sel, [5] ram_sel, [4] write, [3:0] expected waits
   localparam int NVEC = 9;
   localparam logic [7:0] VECS [NVEC] = '{
      8'b1100_0010,   // ROM read -> 2
      8'b1101_0000,   // ROM write -> 0
      8'b1010_0001,   // RAM read -> 1
      8'b1011_0001,   // RAM write -> 1
      8'b0000_0000,   // I/O read -> 0
      8'b0100_0000,   // I/O with ROM flag -> 0
      8'b0011_0000,   // I/O write with RAM flag -> 0
      8'b1110_0010,   // both flags, read -> ROM wins
      8'b1000_0011    // no region -> default 3
   };

   function automatic string tag_of(logic [7:0] v);
      if (!v[7])            return "R5";
      if (v[6] && v[5])     return "R9";
      if (v[6] && v[4])     return "R9";
      if (v[6])             return "R3";
      if (v[5])             return "R4";
      return "R6";
   endfunction

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Runs one bus cycle and returns waits seen and ready before the start edge
   task automatic bus_cycle(input logic mem, input logic rom, input logic ram,
                            input logic wr, output int waits, output int pre_rdy);
      @(negedge clk);
      ale = 1'b1; is_mem = mem; rom_sel = rom; ram_sel = ram;
      rd_n = wr; wr_n = ~wr;
      @(negedge clk);
      pre_rdy = int'(rdy);
      ale = 1'b0;
      waits = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (rdy) break;
         waits++;
      end
      rd_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic idle_check(input string req);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(req, int'(rdy), 1, "ready after wait");
      end
   endtask

   task automatic write_default(input logic [2:0] v);
      @(negedge clk);
      dflt_we = 1'b1; dflt_din = v;
      @(negedge clk);
      dflt_we = 1'b0;
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int w;
      int pre;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", int'(rdy), 1, "ready in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(rdy), 1, "ready after reset");

      for (int k = 0; k < NVEC; k++) begin
         bus_cycle(VECS[k][7], VECS[k][6], VECS[k][5], VECS[k][4], w, pre);
         check(tag_of(VECS[k]), w, int'(VECS[k][3:0]), $sformatf("vector %0d waits", k));
         check("R2", pre, 1, "ready while ale high");
         idle_check("R8");
      end

      // R10: full-range default of 7
      write_default(3'd7);
      bus_cycle(1'b1, 1'b0, 1'b0, 1'b1, w, pre);
      check("R10", w, 7, "default 7 waits");
      idle_check("R8");

      // R7: default of zero keeps ready high
      write_default(3'd0);
      bus_cycle(1'b1, 1'b0, 1'b0, 1'b0, w, pre);
      check("R7", w, 0, "zero count waits");

      // R6: another programmed value
      write_default(3'd5);
      bus_cycle(1'b1, 1'b0, 1'b0, 1'b0, w, pre);
      check("R6", w, 5, "default 5 waits");

      // R1: reset in the middle of a ROM read
      @(negedge clk);
      write_default(3'd6);
      @(negedge clk);
      ale = 1'b1; is_mem = 1'b1; rom_sel = 1'b1; ram_sel = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
      @(negedge clk);
      ale = 1'b0;
      @(negedge clk);
      check("R3", int'(rdy), 0, "ready low in ROM wait");
      rst_n = 1'b0;
      #1;
      check("R1", int'(rdy), 1, "ready after mid-cycle reset");
      @(negedge clk);
      rst_n = 1'b1; rd_n = 1'b1; rom_sel = 1'b0;
      idle_check("R1");

      // R6: default returns to its reset value of 3
      bus_cycle(1'b1, 1'b0, 1'b0, 1'b0, w, pre);
      check("R6", w, 3, "default after reset");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule